// File: doc/BRIEF.md
# Multi-Operand Adder with a 4:2 Compressor Tree

This block adds M operand rows of W bits each in one clock. The rows arrive as a single packed bus and are already aligned by whatever produced them. A carry-save tree built from 4:2 compressor cells reduces the rows to a redundant pair, a sum vector and a carry vector. A final carry-propagate adder then turns that pair into one binary total. The redundant pair and the total are both registered and appear one clock after the rows are sampled. Anything downstream that merges more terms can take the pair. Anything that needs a plain number takes the total.

Each 4:2 cell takes four bits of equal weight and a carry from the column to its right. It gives a sum bit, a carry bit and a carry to the column on its left. That left-going carry is a function of the four primary bits alone, so nothing ripples along a row within a level. Each level of cells halves the row count. When a level's row count is not a multiple of four, three spare rows go through one row of (3,2) counters and one or two spare rows pass straight through. All work is done at the output width W + ceil(log2 M), so the exact sum always fits.

Top module: `csa42_multi_adder`

## Requirements
- R1: One clock after a rising edge at which rst_n is high, total_o equals the exact unsigned sum of the M rows sampled at that edge. Row r occupies bits r*W to r*W+W-1 of rows_i.
- R2: sum_o + carry_o, taken modulo 2^OUTW, equals total_o in every cycle after reset.
- R3: The output width OUTW is W + ceil(log2 M). sum_o + carry_o is below 2^OUTW as an integer, so no carry is lost. For example, M rows of all ones give exactly M*(2^W - 1).
- R4: Reset is synchronous and active low. After a rising edge with rst_n low, sum_o, carry_o and total_o are all zero, whatever rows_i holds.
- R5: The latency is exactly one clock. While rows_i holds steady, total_o holds steady.
- R6: In the compressor cell, the carry to the next column (cout) has the same value for cin = 0 and cin = 1, for all 16 values of the four primary bits.
- R7: The compressor cell keeps the arithmetic value: x0+x1+x2+x3+cin = sum + 2*(carry + cout) for all 32 input combinations.
- R8: Row counts that are not a multiple of four give the exact sum. With M = 5, one level has a (3,2) row and the level before it passes one row through.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| rows_i | input | M*W | Packed operand rows; row r sits at bits [r*W +: W] |
| sum_o | output | OUTW | Registered sum vector of the redundant result |
| carry_o | output | OUTW | Registered carry vector of the redundant result, already weighted |
| total_o | output | OUTW | Registered binary total of all rows |

## Verification
The default 16-row tree is driven with several kinds of input:
- all-zero rows;
- all-ones rows, which fill every column and check that the widened output does not overflow;
- a single set top bit in every row, which stresses the carries out of the top of the input width;
- arithmetic ramps, where each row has a different value and a misplaced row or level shows up;
- pseudo-random rows, which exercise mixed carry patterns.

A five-row instance checks the (3,2) row and the pass-through path, which the power-of-four default never uses. The compressor cell is checked on its own over all 32 inputs: this separates a wrong cout (its dependence on cin) from a wrong sum or carry bit, because the cell's arithmetic identity is checked separately.

// File: rtl/csa42_pkg.sv
`timescale 1ns/1ps
// Package csa42_pkg
// Compile-time planning of the reduction tree. These functions give the
// row count at each level and the number of levels. Elaboration uses
// them only; no hardware comes from this package.
package csa42_pkg;

    // Rows left after one level: groups of four become two, a leftover
    // three becomes two, and a leftover one or two is passed through.
    function automatic int next_rows(input int n);
        int rem;
        if (n <= 2) return n;
        rem = n % 4;
        return 2 * (n / 4) + ((rem == 3) ? 2 : rem);
    endfunction

    // Row count at the input of level lv for a tree fed with m rows.
    function automatic int rows_at(input int m, input int lv);
        int n;
        n = m;
        for (int i = 0; i < lv; i++) n = next_rows(n);
        return n;
    endfunction

    // Number of levels needed to reach at most two rows.
    function automatic int tree_levels(input int m);
        int n;
        int lv;
        n  = m;
        lv = 0;
        while (n > 2) begin
            n  = next_rows(n);
            lv = lv + 1;
        end
        return lv;
    endfunction

endpackage

// File: rtl/csa42_cell.sv
`timescale 1ns/1ps
// Module csa42_cell
// One 4:2 compressor column. It takes four primary bits of equal weight
// and an incoming carry from the column to the right. It gives a sum bit
// of that weight, plus a carry bit and an outgoing column carry, both of
// the next weight.
// The outgoing carry is the majority of x0, x1 and x2, so it never
// depends on cin. The sum goes through three XOR levels.
// Assumes nothing; purely combinational.
module csa42_cell (
    input  logic x0,
    input  logic x1,
    input  logic x2,
    input  logic x3,
    input  logic cin,
    output logic sum,
    output logic carry,
    output logic cout
);
    logic p01;
    logic p23;
    logic p_all;

    // Parity tree and carry selection of the compressor column
    always_comb begin
        p01   = x0 ^ x1;
        p23   = x2 ^ x3;
        p_all = p01 ^ p23;
        cout  = p01 ? x2 : x0;
        sum   = p_all ^ cin;
        carry = p_all ? cin : x3;
    end
endmodule

// File: rtl/csa42_row.sv
`timescale 1ns/1ps
// Module csa42_row
// WD compressor columns side by side, reducing four vectors of width WD
// to a sum vector and a carry vector with the same value modulo 2^WD.
// Column 0 takes a zero cin. Each column's cout feeds the next column's
// cin, but cout does not depend on cin, so there is no ripple.
// Assumes the sum of the four inputs is below 2^WD; the top carries are
// then zero and dropping them loses nothing.
module csa42_row #(
    parameter int WD = 20
) (
    input  logic [WD-1:0] a,
    input  logic [WD-1:0] b,
    input  logic [WD-1:0] c,
    input  logic [WD-1:0] d,
    output logic [WD-1:0] s,
    output logic [WD-1:0] cv
);
    logic [WD:0]   link;
    logic [WD-1:0] cy;

    assign link[0] = 1'b0;

    for (genvar i = 0; i < WD; i++) begin : g_col
        csa42_cell u_cell (
            .x0   (a[i]),
            .x1   (b[i]),
            .x2   (c[i]),
            .x3   (d[i]),
            .cin  (link[i]),
            .sum  (s[i]),
            .carry(cy[i]),
            .cout (link[i+1])
        );
    end

    // Carry bits move up one weight; the column-0 slot is empty
    if (WD > 1) begin : g_shift
        assign cv = {cy[WD-2:0], 1'b0};
    end else begin : g_shift1
        assign cv = '0;
    end
endmodule

// File: rtl/csa32_row.sv
`timescale 1ns/1ps
// Module csa32_row
// A row of (3,2) counters that reduces three vectors to a sum vector and
// a carry vector. The tree uses it when a level holds three leftover
// rows. Assumes the three inputs add up to less than 2^WD.
module csa32_row #(
    parameter int WD = 20
) (
    input  logic [WD-1:0] a,
    input  logic [WD-1:0] b,
    input  logic [WD-1:0] c,
    output logic [WD-1:0] s,
    output logic [WD-1:0] cv
);
    logic [WD-1:0] maj;

    // Full-adder sum and majority per column
    always_comb begin
        s   = a ^ b ^ c;
        maj = (a & b) | (a & c) | (b & c);
    end

    if (WD > 1) begin : g_shift
        assign cv = {maj[WD-2:0], 1'b0};
    end else begin : g_shift1
        assign cv = '0;
    end
endmodule

// File: rtl/csa42_cpa.sv
`timescale 1ns/1ps
// Module csa42_cpa
// Final carry-propagate adder that turns the redundant pair into one
// binary value. Assumes the true sum fits in WD bits.
module csa42_cpa #(
    parameter int WD = 20
) (
    input  logic [WD-1:0] a,
    input  logic [WD-1:0] b,
    output logic [WD-1:0] y
);
    logic [WD:0] carry;

    // Ripple carry chain, one generate/propagate stage per bit
    always_comb begin
        carry[0] = 1'b0;
        for (int i = 0; i < WD; i++) begin
            y[i]       = a[i] ^ b[i] ^ carry[i];
            carry[i+1] = (a[i] & b[i]) | (carry[i] & (a[i] ^ b[i]));
        end
    end
endmodule

// File: rtl/csa42_multi_adder.sv
`timescale 1ns/1ps
// Module csa42_multi_adder
// Adds M rows of W bits. A level-by-level carry-save tree, made of 4:2
// compressor rows, reduces them to two vectors. Leftover rows in a level
// use a (3,2) row or pass through. A carry-propagate adder then gives
// the total. The redundant pair and the total are registered: one cycle
// of latency.
// Assumes M >= 1 and W >= 1. Rows are unsigned, or already aligned by
// the producer.
module csa42_multi_adder #(
    parameter  int W    = 16,
    parameter  int M    = 16,
    localparam int OUTW = W + $clog2(M)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [M*W-1:0]  rows_i,
    output logic [OUTW-1:0] sum_o,
    output logic [OUTW-1:0] carry_o,
    output logic [OUTW-1:0] total_o
);
    import csa42_pkg::*;

    localparam int LV     = tree_levels(M);
    localparam int N_LAST = rows_at(M, LV);

    logic [OUTW-1:0] node [0:LV][0:M-1];
    logic [OUTW-1:0] red_s;
    logic [OUTW-1:0] red_c;
    logic [OUTW-1:0] tot_w;

    // Level 0: rows widened to the output width
    for (genvar r = 0; r < M; r++) begin : g_in
        assign node[0][r] = OUTW'(rows_i[r*W +: W]);
    end

    // Reduction levels
    for (genvar l = 0; l < LV; l++) begin : g_lvl
        localparam int N   = rows_at(M, l);
        localparam int NG  = N / 4;
        localparam int REM = N % 4;
        localparam int NN  = next_rows(N);

        for (genvar g = 0; g < NG; g++) begin : g_grp
            csa42_row #(.WD(OUTW)) u_row (
                .a (node[l][4*g]),
                .b (node[l][4*g+1]),
                .c (node[l][4*g+2]),
                .d (node[l][4*g+3]),
                .s (node[l+1][2*g]),
                .cv(node[l+1][2*g+1])
            );
        end

        if (REM == 3) begin : g_three
            csa32_row #(.WD(OUTW)) u_fa (
                .a (node[l][4*NG]),
                .b (node[l][4*NG+1]),
                .c (node[l][4*NG+2]),
                .s (node[l+1][2*NG]),
                .cv(node[l+1][2*NG+1])
            );
        end else begin : g_pass
            for (genvar p = 0; p < REM; p++) begin : g_p
                assign node[l+1][2*NG+p] = node[l][4*NG+p];
            end
        end

        for (genvar z = NN; z < M; z++) begin : g_zero
            assign node[l+1][z] = '0;
        end
    end

    // Pick the surviving pair
    assign red_s = node[LV][0];
    if (N_LAST >= 2) begin : g_pair
        assign red_c = node[LV][1];
    end else begin : g_single
        assign red_c = '0;
    end

    csa42_cpa #(.WD(OUTW)) u_cpa (
        .a(red_s),
        .b(red_c),
        .y(tot_w)
    );

    // Output register with synchronous active-low clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_o   <= '0;
            carry_o <= '0;
            total_o <= '0;
        end else begin
            sum_o   <= red_s;
            carry_o <= red_c;
            total_o <= tot_w;
        end
    end
endmodule

// Module csa42_multi_adder_chk
// Property checker bound to every csa42_multi_adder instance.
module csa42_multi_adder_chk #(
    parameter  int W    = 16,
    parameter  int M    = 16,
    localparam int OUTW = W + $clog2(M)
) (
    input logic            clk,
    input logic            rst_n,
    input logic [M*W-1:0]  rows_i,
    input logic [OUTW-1:0] sum_o,
    input logic [OUTW-1:0] carry_o,
    input logic [OUTW-1:0] total_o
);
    logic [OUTW-1:0] ref_w;
    logic [OUTW:0]   pair_w;
    logic            rst_prev_q;

    // Behavioural reference sum of the present rows
    always_comb begin
        ref_w = '0;
        for (int r = 0; r < M; r++) ref_w = ref_w + OUTW'(rows_i[r*W +: W]);
        pair_w = {1'b0, sum_o} + {1'b0, carry_o};
    end

    // Remember whether reset was applied at the previous edge
    always_ff @(posedge clk) rst_prev_q <= !rst_n;

    // R4
    always @(posedge clk) begin
        if (rst_prev_q) begin
            reset_clear_chk: assert (sum_o == '0 && carry_o == '0 && total_o == '0);
        end
    end

    // R1
    exact_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (total_o == $past(ref_w)));

    // R2
    pair_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pair_w[OUTW-1:0] == total_o);

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pair_w[OUTW] == 1'b0);

    // R5
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(rows_i) && $past(rst_n)) |=> $stable(total_o));
endmodule

bind csa42_multi_adder csa42_multi_adder_chk #(.W(W), .M(M)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .rows_i (rows_i),
    .sum_o  (sum_o),
    .carry_o(carry_o),
    .total_o(total_o)
);

// File: tb/csa42_multi_adder_tb.sv
`timescale 1ns/1ps
module csa42_multi_adder_tb;
    localparam int W   = 16;
    localparam int M   = 16;
    localparam int OW  = W + $clog2(M);
    localparam int W5  = 8;
    localparam int M5  = 5;
    localparam int OW5 = W5 + $clog2(M5);

    // Pattern table: {base, stride}; row r = base + r*stride (mod 2^W)
    localparam logic [31:0] PAT_TAB [0:5] = '{
        {16'h0000, 16'h0000},
        {16'hFFFF, 16'h0000},
        {16'h0001, 16'h0001},
        {16'h8000, 16'h0000},
        {16'h1234, 16'h1111},
        {16'hFFFF, 16'hFFFF}
    };

    logic            clk;
    logic            rst_n;
    logic [M*W-1:0]  rows;
    logic [OW-1:0]   sum_o, carry_o, total_o;
    logic [M5*W5-1:0] rows5;
    logic [OW5-1:0]  sum5, carry5, total5;
    logic            cx0, cx1, cx2, cx3, ccin, csum, ccarry, ccout;

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    logic [31:0] lfsr = 32'hACE1_2468;

    csa42_multi_adder #(.W(W), .M(M)) u_dut (
        .clk(clk), .rst_n(rst_n), .rows_i(rows),
        .sum_o(sum_o), .carry_o(carry_o), .total_o(total_o));

    csa42_multi_adder #(.W(W5), .M(M5)) u_dut5 (
        .clk(clk), .rst_n(rst_n), .rows_i(rows5),
        .sum_o(sum5), .carry_o(carry5), .total_o(total5));

    csa42_cell u_cell (
        .x0(cx0), .x1(cx1), .x2(cx2), .x3(cx3), .cin(ccin),
        .sum(csum), .carry(ccarry), .cout(ccout));

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [OW-1:0] ref16(input logic [M*W-1:0] r);
        logic [OW-1:0] acc = '0;
        for (int i = 0; i < M; i++) acc = acc + OW'(r[i*W +: W]);
        return acc;
    endfunction

    function automatic logic [OW5-1:0] ref5(input logic [M5*W5-1:0] r);
        logic [OW5-1:0] acc = '0;
        for (int i = 0; i < M5; i++) acc = acc + OW5'(r[i*W5 +: W5]);
        return acc;
    endfunction

    task automatic next_rand();
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    endtask

    // Apply rows at a falling edge and check after the next rising edge
    task automatic apply16(input logic [M*W-1:0] r, input string req);
        logic [OW:0] pair;
        rows = r;
        @(negedge clk);
        check(req, 64'(total_o), 64'(ref16(r)));                       // R1
        pair = {1'b0, sum_o} + {1'b0, carry_o};
        check("R2 pair equals total", 64'(pair[OW-1:0]), 64'(total_o)); // R2
        check("R3 no carry beyond OUTW", 64'(pair[OW]), 64'd0);         // R3
    endtask

    task automatic apply5(input logic [M5*W5-1:0] r);
        rows5 = r;
        @(negedge clk);
        check("R8 five-row total", 64'(total5), 64'(ref5(r)));
        check("R8 five-row pair", 64'(OW5'(sum5 + carry5)), 64'(ref5(r)));
    endtask

    // Watchdog
    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [M*W-1:0] r;
        rst_n = 1'b0;
        rows  = '1;
        rows5 = '1;
        {cx0, cx1, cx2, cx3, ccin} = '0;
        @(negedge clk);
        @(negedge clk);
        // R4: outputs clear under reset despite nonzero rows
        check("R4 sum in reset", 64'(sum_o), 64'd0);
        check("R4 carry in reset", 64'(carry_o), 64'd0);
        check("R4 total in reset", 64'(total_o), 64'd0);
        check("R4 five-row total in reset", 64'(total5), 64'd0);
        rst_n = 1'b1;

        // R1/R2/R3: table of patterns
        for (int t = 0; t < 6; t++) begin
            for (int i = 0; i < M; i++)
                r[i*W +: W] = PAT_TAB[t][31:16] + W'(i) * PAT_TAB[t][15:0];
            apply16(r, "R1 table pattern");
        end

        // R3: all-ones gives M*(2^W-1) exactly
        apply16('1, "R3 all-ones total");
        check("R3 all-ones value", 64'(total_o), 64'(M) * 64'((1 << W) - 1));

        // R1: single nonzero row in each position
        for (int i = 0; i < M; i++) begin
            r = '0;
            r[i*W +: W] = W'(16'h0101 << (i % 8));
            apply16(r, "R1 single row");
        end

        // R1: pseudo-random rows
        for (int k = 0; k < 40; k++) begin
            for (int i = 0; i < M; i++) begin
                next_rand();
                r[i*W +: W] = lfsr[W-1:0];
            end
            apply16(r, "R1 random rows");
        end

        // R5: rows held for several cycles keep the total steady
        for (int i = 0; i < M; i++) r[i*W +: W] = W'(16'h0F0F + i);
        rows = r;
        @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R5 held total", 64'(total_o), 64'(ref16(r)));
        end

        // R4: reset asserted mid-run clears outputs
        rst_n = 1'b0;
        @(negedge clk);
        check("R4 mid-run clear total", 64'(total_o), 64'd0);
        check("R4 mid-run clear sum", 64'(sum_o), 64'd0);
        rst_n = 1'b1;
        apply16(r, "R1 after reset release");

        // R8: five-row instance, (3,2) and pass-through path
        apply5('0);
        apply5('1);
        check("R8 five-row all-ones", 64'(total5), 64'(M5 * 255));
        for (int k = 0; k < 10; k++) begin
            next_rand();
            rows5 = {lfsr[7:0], lfsr[15:8], lfsr[23:16], lfsr[31:24], lfsr[11:4]};
            apply5(rows5);
        end

        // R6/R7: exhaustive compressor cell
        for (int v = 0; v < 16; v++) begin
            logic cout0;
            int lhs;
            int rhs;
            for (int ci = 0; ci < 2; ci++) begin
                {cx3, cx2, cx1, cx0} = v[3:0];
                ccin = ci[0];
                #1;
                lhs = int'(cx0) + int'(cx1) + int'(cx2) + int'(cx3) + ci;
                rhs = int'(csum) + 2 * (int'(ccarry) + int'(ccout));
                check("R7 cell identity", 64'(rhs), 64'(lhs));
                if (ci == 0) cout0 = ccout;
                else check("R6 cout independent of cin", 64'(ccout), 64'(cout0));
            end
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule